// File: doc/BRIEF.md
# Three-Input Status Light Controller

This controller watches three single-bit condition inputs and drives a green, a yellow and a red indicator lamp. Only the number of inputs that are high matters, never which ones. Every clock edge sorts the inputs into one of four classes: none high, exactly one high, exactly two high, or all three high. That class then selects a lamp pattern that is steady, steady and then flashing, or a latched alarm.

One high input lights yellow steadily. When that class has held for a configurable run of cycles (ten by default, five seconds with a half-second clock), yellow starts toggling. Two high inputs light red steadily. When that class has held for the same run, the controller latches an alarm. All three inputs high latch the alarm at once. While the alarm is latched, red toggles every cycle whatever the inputs do, and only reset clears it. The run count restarts whenever the class changes.

Top module: `tri_status_lamp`

## Requirements
- R1: The lamp pattern depends only on how many of the three cond_i bits are high. Switching from one input pattern to another with the same number of high bits keeps the run count going without a break.
- R2: With no alarm latched, a clock edge that samples all inputs low gives green=1, yellow=0, red=0 after that edge.
- R3: Let k be the number of consecutive edges, counting the current one, that have sampled exactly one input high. While k < DELAY_CYCLES, yellow is steadily 1 and the other lamps are 0.
- R4: From the edge where k reaches DELAY_CYCLES, yellow flashes. It is 0 after that first edge and then inverts on every following edge for as long as exactly one input stays high.
- R5: While exactly two inputs are high and their run k < DELAY_CYCLES, red is steadily 1. At the edge where k reaches DELAY_CYCLES, the alarm latches.
- R6: An edge that samples all three inputs high latches the alarm at that same edge.
- R7: While the alarm is latched, green and yellow are 0 and red flashes. Red is 0 after the latching edge if no lamp was flashing before; otherwise it carries on inverting the existing flash phase. After that it inverts on every edge, whatever the inputs do.
- R8: When the class changes before the run completes, the count restarts. The new class shows at once, and re-entering the one-high or two-high class starts again from k=1.
- R9: At most one lamp is 1 at any time.
- R10: Reset (rst_ni low) gives green=1, yellow=0, red=0 and clears the alarm. Nothing else clears the alarm.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, nominally one tick per half second |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cond_i | input | 3 | The three condition inputs |
| green_o | output | 1 | Green lamp |
| yellow_o | output | 1 | Yellow lamp |
| red_o | output | 1 | Red lamp |

## Verification
The bench builds the controller with DELAY_CYCLES at its default of ten. Every steady phase is then short enough to run to completion several times, and runs of nine and ten cycles can both be placed exactly. That makes the boundary between steady and flashing, and between steady red and a latched alarm, observable on either side. Input patterns with the same count are swapped in the middle of a run to show that the count does not depend on which inputs are high. The alarm is raised through both paths, including from a yellow flash that is already running, and it is cleared only by reset.

// File: rtl/tsl_pkg.sv
package tsl_pkg;
  typedef enum logic [1:0] {
    CLS_NONE = 2'd0,
    CLS_ONE  = 2'd1,
    CLS_TWO  = 2'd2,
    CLS_ALL  = 2'd3
  } cls_e;
endpackage

// File: rtl/tsl_classify.sv
module tsl_classify
  import tsl_pkg::*;
#(
  parameter int N_COND = 3
) (
  input  logic [N_COND-1:0] cond_i,
  output cls_e              cls_o
);
  localparam int SUM_W = $clog2(N_COND + 1);

  logic [SUM_W-1:0] part [N_COND+1];

  assign part[0] = '0;
  for (genvar g = 0; g < N_COND; g++) begin : g_sum
    assign part[g+1] = part[g] + SUM_W'(cond_i[g]);
  end

  assign cls_o = cls_e'(part[N_COND][1:0]);
endmodule

// File: rtl/tsl_run_timer.sv
module tsl_run_timer
  import tsl_pkg::*;
#(
  parameter int DELAY_CYCLES = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  cls_e cls_i,
  output cls_e cls_q_o,
  output logic hit_o
);
  localparam int CNT_W = $clog2(DELAY_CYCLES + 1);
  localparam logic [CNT_W-1:0] DLY = CNT_W'(DELAY_CYCLES);

  cls_e             cls_q;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             timed;

  assign timed = (cls_i == CLS_ONE) || (cls_i == CLS_TWO);

  always_comb begin
    if (!timed)               cnt_d = '0;
    else if (cls_i != cls_q)  cnt_d = CNT_W'(1);
    else if (cnt_q == DLY)    cnt_d = DLY;
    else                      cnt_d = cnt_q + CNT_W'(1);
  end

  assign hit_o   = timed && (cnt_d == DLY);
  assign cls_q_o = cls_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cls_q <= CLS_NONE;
      cnt_q <= '0;
    end else begin
      cls_q <= cls_i;
      cnt_q <= cnt_d;
    end
  end

  p_cnt_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= DLY);
  p_restart_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (timed && cls_i != cls_q) |=> (cnt_q == CNT_W'(1)));
endmodule

// File: rtl/tsl_alarm_flash.sv
module tsl_alarm_flash
  import tsl_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  cls_e cls_i,
  input  logic hit_i,
  output logic alarm_o,
  output logic flash_o,
  output logic blink_o
);
  logic alarm_q, flash_q, blink_q;
  logic alarm_d, flash_d;

  assign alarm_d = alarm_q || (cls_i == CLS_ALL) || ((cls_i == CLS_TWO) && hit_i);
  assign flash_d = alarm_d || ((cls_i == CLS_ONE) && hit_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      alarm_q <= 1'b0;
      flash_q <= 1'b0;
      blink_q <= 1'b1;
    end else begin
      alarm_q <= alarm_d;
      flash_q <= flash_d;
      // a fresh flash begins dark; a running one keeps inverting
      blink_q <= flash_d ? (flash_q ? ~blink_q : 1'b0) : 1'b1;
    end
  end

  assign alarm_o = alarm_q;
  assign flash_o = flash_q;
  assign blink_o = blink_q;

  p_alarm_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alarm_q |=> alarm_q);
  p_all_sets_alarm_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cls_i == CLS_ALL) |=> alarm_q);
endmodule

// File: rtl/tsl_lamp_drive.sv
module tsl_lamp_drive
  import tsl_pkg::*;
(
  input  cls_e cls_i,
  input  logic alarm_i,
  input  logic flash_i,
  input  logic blink_i,
  output logic green_o,
  output logic yellow_o,
  output logic red_o
);
  always_comb begin
    green_o  = 1'b0;
    yellow_o = 1'b0;
    red_o    = 1'b0;
    if (alarm_i) begin
      red_o = blink_i;
    end else begin
      unique case (cls_i)
        CLS_NONE: green_o  = 1'b1;
        CLS_ONE:  yellow_o = flash_i ? blink_i : 1'b1;
        CLS_TWO:  red_o    = 1'b1;
        default:  red_o    = blink_i;
      endcase
    end
  end

  always_comb begin
    a_one_lamp_r9: assert ($countones({green_o, yellow_o, red_o}) <= 1);
  end
endmodule

// File: rtl/tri_status_lamp.sv
module tri_status_lamp
  import tsl_pkg::*;
#(
  parameter int DELAY_CYCLES = 10
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] cond_i,
  output logic       green_o,
  output logic       yellow_o,
  output logic       red_o
);
  cls_e cls_now, cls_q;
  logic hit, alarm, flash, blink;

  tsl_classify #(.N_COND(3)) u_classify (
    .cond_i (cond_i),
    .cls_o  (cls_now)
  );

  tsl_run_timer #(.DELAY_CYCLES(DELAY_CYCLES)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cls_i   (cls_now),
    .cls_q_o (cls_q),
    .hit_o   (hit)
  );

  tsl_alarm_flash u_alarm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cls_i   (cls_now),
    .hit_i   (hit),
    .alarm_o (alarm),
    .flash_o (flash),
    .blink_o (blink)
  );

  tsl_lamp_drive u_lamps (
    .cls_i    (cls_q),
    .alarm_i  (alarm),
    .flash_i  (flash),
    .blink_i  (blink),
    .green_o  (green_o),
    .yellow_o (yellow_o),
    .red_o    (red_o)
  );

  p_red_toggle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alarm |=> (red_o != $past(red_o)));
  p_alarm_dark_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alarm |-> (!green_o && !yellow_o));
  p_green_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cond_i == 3'b000 && !alarm) |=> green_o);
endmodule

// File: tb/tri_status_lamp_bench.sv
module tri_status_lamp_bench;
  localparam int CLK_PERIOD = 10;
  localparam int D = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] cond = 3'b000;
  logic g, y, r;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit finished = 0;

  // reference model state
  int m_cls = 0, m_len = 0;
  bit m_alarm = 0, m_flash = 0, m_blink = 1;

  always #(CLK_PERIOD/2) clk = ~clk;

  tri_status_lamp #(.DELAY_CYCLES(D)) u_tri_status_lamp (
    .clk_i(clk), .rst_ni(rst_n), .cond_i(cond),
    .green_o(g), .yellow_o(y), .red_o(r)
  );

  function automatic int popc(input logic [2:0] v);
    return int'(v[0]) + int'(v[1]) + int'(v[2]);
  endfunction

  task automatic model_reset();
    m_cls = 0; m_len = 0; m_alarm = 0; m_flash = 0; m_blink = 1;
  endtask

  always @(posedge clk) begin
    if (!rst_n) model_reset();
    else begin
      int c;
      bit hit, na, nf;
      c = popc(cond);
      if (c == 1 || c == 2) m_len = (c == m_cls) ? ((m_len < D) ? m_len + 1 : D) : 1;
      else m_len = 0;
      m_cls = c;
      hit = (c == 1 || c == 2) && (m_len == D);
      na = m_alarm || (c == 3) || (c == 2 && hit);
      nf = na || (c == 1 && hit);
      m_blink = nf ? (m_flash ? ~m_blink : 1'b0) : 1'b1;
      m_flash = nf;
      m_alarm = na;
    end
  end

  task automatic expect_lamps(output bit eg, output bit ey, output bit er);
    eg = 0; ey = 0; er = 0;
    if (m_alarm) er = m_blink;
    else if (m_cls == 0) eg = 1;
    else if (m_cls == 1) ey = m_flash ? m_blink : 1'b1;
    else er = 1;
  endtask

  task automatic check(input string tag);
    bit eg, ey, er;
    expect_lamps(eg, ey, er);
    total++;
    if ({g, y, r} !== {eg, ey, er}) begin
      bad++;
      $display("FAIL %s: got gyr=%b%b%b expected %b%b%b at cycle %0d", tag, g, y, r, eg, ey, er, cycles);
    end
    total++;
    if ($countones({g, y, r}) > 1) begin
      bad++;
      $display("FAIL R9: got gyr=%b%b%b expected at most one lamp", g, y, r);
    end
  endtask

  function automatic string mode_tag();
    if (m_alarm) return "R7";
    if (m_cls == 0) return "R2";
    if (m_cls == 1) return m_flash ? "R4" : "R3";
    return "R5";
  endfunction

  always @(negedge clk) begin
    cycles++;
    if (rst_n && !finished) check(mode_tag());
  end

  task automatic hold(input logic [2:0] v, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cond = v;
    end
  endtask

  task automatic expect_bits(input string tag, input bit eg, input bit ey, input bit er);
    total++;
    if ({g, y, r} !== {eg, ey, er}) begin
      bad++;
      $display("FAIL %s: got gyr=%b%b%b expected %b%b%b", tag, g, y, r, eg, ey, er);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    cond = 3'b000;
    model_reset();
    #1;
    expect_bits("R10", 1, 0, 0);
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    do_reset();
    // R3/R4: one input for 15 edges
    hold(3'b001, 1);
    hold(3'b001, 14);
    hold(3'b000, 3);
    // R1: same count, different inputs, run continues to flash
    hold(3'b010, 5);
    hold(3'b100, 5);
    @(negedge clk); #1;
    expect_bits("R1", 0, 0, 0);  // tenth edge: flash starts dark
    hold(3'b100, 3);
    // R8: interrupted run restarts
    hold(3'b000, 1);
    hold(3'b001, 4);
    hold(3'b000, 1);
    hold(3'b010, 9);
    @(negedge clk); #1;
    expect_bits("R8", 0, 1, 0);
    hold(3'b011, 9);
    hold(3'b001, 2);
    @(negedge clk); #1;
    expect_bits("R8", 0, 1, 0);
    hold(3'b000, 2);
    // R5: two high, patterns swapped, alarm at tenth edge
    hold(3'b011, 5);
    hold(3'b101, 5);
    @(negedge clk); #1;
    expect_bits("R5", 0, 0, 0);
    hold(3'b000, 6);
    hold(3'b001, 4);
    // R6: all three, one edge, then low
    do_reset();
    hold(3'b111, 1);
    @(negedge clk); #1;
    expect_bits("R6", 0, 0, 0);
    hold(3'b000, 5);
    // alarm from a running yellow flash
    do_reset();
    hold(3'b100, 13);
    hold(3'b111, 1);
    hold(3'b000, 4);
    // walk all patterns
    do_reset();
    for (int p = 0; p < 8; p++) hold(3'(p), 3);
    hold(3'b000, 2);
    @(negedge clk);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule